// File: doc/BRIEF.md
# Strand Timer and Soft-Interrupt Register Block

This block holds the timekeeping and soft-interrupt state of a single processor strand. Two free-running 64-bit counters advance once per clock: a tick count and a system tick count. Three 64-bit compare registers watch them. The tick compare and the system-tick compare watch their own counters. The hypervisor compare watches the system tick count. When an armed compare meets its counter, it latches an interrupt-pending bit. That bit stays set until software clears it.

Software reaches the block through one access port. The port has a valid strobe, a write flag, a 4-bit address and 64-bit write data. Read data and an access-error flag come back combinationally in the same cycle. The soft-interrupt vector can be written whole, or changed bit by bit through a set alias and a clear alias. The block also holds a trap-base register whose low 15 bits always read as zero, and a read-only version word built from parameters. Interrupt prioritisation and trap delivery happen outside this block.

Top module: `strand_timer_regs`

## Requirements
- R1: Both counters read 0 in the first cycle after reset and rise by exactly one per clock. The tick count is read at address 0 and the system tick count at address 1.
- R2: A write to the tick compare (address 2) arms it when bit 63 is 0 and bits 62:0 exceed the tick count in the write cycle. When the count reaches that value, bit 0 of the soft-interrupt vector is set from the next cycle on.
- R3: The system-tick compare (address 3) sets soft-interrupt bit 16 on a match. The hypervisor compare (address 4) is matched against the system tick count and sets the separate `hint_o` pending bit. Neither compare touches the other bits.
- R4: A compare written with bit 63 set never raises its pending bit.
- R5: A compare whose bits 62:0 are not greater than the counter in the write cycle never raises its pending bit.
- R6: Rewriting a compare before it matches cancels the earlier target. Only the new value counts.
- R7: Pending bits stay set until software clears them. The soft-interrupt vector (17 bits) is written directly at address 5. The hypervisor pending bit is bit 0 of address 8 for reads and writes.
- R8: A write to address 6 stores the current soft-interrupt value OR the write data.
- R9: A write to address 7 stores the current soft-interrupt value AND the inverted write data.
- R10: The trap-base register (address 9) stores the written value with bits 14:0 forced to 0. A read also returns bits 14:0 as 0.
- R11: Address 10 reads the version word. Bits 7:0 hold the window count, bits 15:8 the maximum trap level and bits 23:16 the maximum global level. All other bits are 0.
- R12: `acc_err` is raised, and no state changes, for a write to address 0, 1 or 10, and for any access to addresses 11 to 15.
- R13: The compare registers read back all 64 written bits, and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 64 | Write data |
| rd_data | output | 64 | Read data, valid in the cycle of the read |
| acc_err | output | 1 | Illegal access in this cycle |
| softint_o | output | 17 | Soft-interrupt vector |
| hint_o | output | 1 | Hypervisor compare pending bit |

## Verification
The checker enforces the following on every cycle:
- The tick counter steps by one.
- Each compare match is followed one cycle later by its pending bit.
- A compare with its disable bit set never produces a match.
- Pending bits hold unless software writes the register that can clear them.
- Trap-base reads return zero low bits.
- A version write flags an error.

Some properties depend on the counter value at the moment of a write, so only the bench's directed scenarios can show them. These are:
- The exact cycle in which a match lands.
- The refusal of targets that are already past.
- The cancellation by a rewrite.
- The arithmetic of the set and clear aliases.

// File: rtl/stv_pkg.sv
`timescale 1ns/1ps
package stv_pkg;
  localparam int DW        = 64;
  localparam int AW        = 4;
  localparam int NCNT      = 2;
  localparam int NSLOT     = 3;
  localparam int TICK_BIT  = 0;
  localparam int STICK_BIT = 16;

  typedef enum logic [AW-1:0] {
    A_TICK  = 4'd0,
    A_STICK = 4'd1,
    A_TCMP  = 4'd2,
    A_SCMP  = 4'd3,
    A_HCMP  = 4'd4,
    A_SOFT  = 4'd5,
    A_SSET  = 4'd6,
    A_SCLR  = 4'd7,
    A_HINT  = 4'd8,
    A_TBA   = 4'd9,
    A_VER   = 4'd10
  } reg_addr_e;

  // Compare slot s is mapped at A_TCMP + s
  function automatic logic [AW-1:0] slot_addr(input int s);
    return AW'(int'(A_TCMP) + s);
  endfunction

  // A target arms only if enabled and strictly ahead of the counter
  function automatic logic arm_ok(input logic [DW-1:0] val, input logic [DW-2:0] cnt);
    return !val[DW-1] && (val[DW-2:0] > cnt);
  endfunction

  function automatic logic [DW-1:0] tba_clean(input logic [DW-1:0] v, input int zb);
    return v & ~((DW'(1) << zb) - DW'(1));
  endfunction

  function automatic logic [DW-1:0] version_word(input int win, input int tl, input int gl);
    logic [7:0] w8, t8, g8;
    w8 = win[7:0];
    t8 = tl[7:0];
    g8 = gl[7:0];
    return DW'({g8, t8, w8});
  endfunction
endpackage

// File: rtl/stv_cmp_slot.sv
`timescale 1ns/1ps
module stv_cmp_slot
  import stv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [DW-2:0] cnt,
  output logic [DW-1:0] cmp_q,
  output logic          armed_q,
  output logic          fire
);
  assign fire = armed_q && (cmp_q[DW-2:0] == cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      armed_q <= 1'b0;
    end else if (wr_en) begin
      cmp_q   <= wdata;
      armed_q <= arm_ok(wdata, cnt);
    end else if (fire) begin
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/stv_softint_reg.sv
`timescale 1ns/1ps
module stv_softint_reg #(
  parameter int SOFT_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_dir,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [SOFT_W-1:0] wdata,
  input  logic [SOFT_W-1:0] hw_set,
  output logic [SOFT_W-1:0] q
);
  function automatic logic [SOFT_W-1:0] sw_next(
    input logic [SOFT_W-1:0] cur, input logic [SOFT_W-1:0] d,
    input logic dir, input logic set, input logic clr);
    if (dir)      return d;
    else if (set) return cur | d;
    else if (clr) return cur & ~d;
    else          return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= sw_next(q, wdata, wr_dir, wr_set, wr_clr) | hw_set;
  end
endmodule

// File: rtl/strand_timer_regs.sv
`timescale 1ns/1ps
module strand_timer_regs
  import stv_pkg::*;
#(
  parameter int WIN_COUNT     = 8,
  parameter int MAX_TL        = 6,
  parameter int MAX_GL        = 3,
  parameter int TBA_ZERO_BITS = 15,
  parameter int SOFT_W        = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic [DW-1:0]     rd_data,
  output logic              acc_err,
  output logic [SOFT_W-1:0] softint_o,
  output logic              hint_o
);
  localparam logic [DW-1:0] VER_WORD = version_word(WIN_COUNT, MAX_TL, MAX_GL);

  logic [DW-1:0] cnt_q [NCNT];
  logic [DW-1:0] tick_cnt, stick_cnt;
  logic [DW-1:0] cmp_val [NSLOT];
  logic [NSLOT-1:0] cmp_armed, cmp_fire, cmp_dis;
  logic [SOFT_W-1:0] softint_q, hw_set;
  logic [DW-1:0] tba_q;
  logic hint_q;
  logic wr_go, ro_hit, unmapped;

  // Free-running counters
  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[c] <= '0;
      else        cnt_q[c] <= cnt_q[c] + DW'(1);
    end
  end
  assign tick_cnt  = cnt_q[0];
  assign stick_cnt = cnt_q[1];

  // Access decode
  assign unmapped = (req_addr > A_VER);
  assign ro_hit   = (req_addr == A_TICK) || (req_addr == A_STICK) || (req_addr == A_VER);
  assign acc_err  = req_valid && (unmapped || (req_we && ro_hit));
  assign wr_go    = req_valid && req_we && !acc_err;

  // Compare slots: slot 0 watches tick, slots 1 and 2 watch system tick
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int SRC = (s == 0) ? 0 : 1;
    stv_cmp_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_go && (req_addr == slot_addr(s))),
      .wdata   (req_wdata),
      .cnt     (cnt_q[SRC][DW-2:0]),
      .cmp_q   (cmp_val[s]),
      .armed_q (cmp_armed[s]),
      .fire    (cmp_fire[s])
    );
    assign cmp_dis[s] = cmp_val[s][DW-1];
  end

  always_comb begin
    hw_set            = '0;
    hw_set[TICK_BIT]  = cmp_fire[0];
    hw_set[STICK_BIT] = cmp_fire[1];
  end

  stv_softint_reg #(.SOFT_W(SOFT_W)) u_soft (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_dir (wr_go && (req_addr == A_SOFT)),
    .wr_set (wr_go && (req_addr == A_SSET)),
    .wr_clr (wr_go && (req_addr == A_SCLR)),
    .wdata  (req_wdata[SOFT_W-1:0]),
    .hw_set (hw_set),
    .q      (softint_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hint_q <= 1'b0;
      tba_q  <= '0;
    end else begin
      if (wr_go && (req_addr == A_HINT)) hint_q <= req_wdata[0] | cmp_fire[2];
      else                               hint_q <= hint_q | cmp_fire[2];
      if (wr_go && (req_addr == A_TBA))  tba_q  <= tba_clean(req_wdata, TBA_ZERO_BITS);
    end
  end

  always_comb begin
    rd_data = '0;
    if (req_valid && !req_we) begin
      case (req_addr)
        A_TICK:                 rd_data = tick_cnt;
        A_STICK:                rd_data = stick_cnt;
        A_TCMP:                 rd_data = cmp_val[0];
        A_SCMP:                 rd_data = cmp_val[1];
        A_HCMP:                 rd_data = cmp_val[2];
        A_SOFT, A_SSET, A_SCLR: rd_data = DW'(softint_q);
        A_HINT:                 rd_data = DW'(hint_q);
        A_TBA:                  rd_data = tba_clean(tba_q, TBA_ZERO_BITS);
        A_VER:                  rd_data = VER_WORD;
        default:                rd_data = '0;
      endcase
    end
  end

  assign softint_o = softint_q;
  assign hint_o    = hint_q;
endmodule

// File: rtl/stv_checker.sv
`timescale 1ns/1ps
module stv_checker #(
  parameter int TBA_ZERO_BITS = 15
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_we,
  input logic [3:0]  req_addr,
  input logic [63:0] rd_data,
  input logic        acc_err,
  input logic        soft_tick,
  input logic        soft_stick,
  input logic        hint_o,
  input logic [63:0] tick_cnt,
  input logic [2:0]  cmp_fire,
  input logic [2:0]  cmp_dis
);
  localparam logic [63:0] LOW_MASK = (64'd1 << TBA_ZERO_BITS) - 64'd1;

  logic sw_soft_clear, sw_hint_write;
  assign sw_soft_clear = req_valid && req_we && ((req_addr == 4'd5) || (req_addr == 4'd7));
  assign sw_hint_write = req_valid && req_we && (req_addr == 4'd8);

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> tick_cnt == $past(tick_cnt) + 64'd1);

  assert_tick_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire[0] |=> soft_tick);

  assert_stick_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire[1] |=> soft_stick);

  assert_hyp_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire[2] |=> hint_o);

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire & cmp_dis) == 3'b000);

  assert_soft_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_tick && !sw_soft_clear) |=> soft_tick);

  assert_hint_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_o && !sw_hint_write) |=> hint_o);

  assert_tba_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && req_addr == 4'd9) |-> (rd_data & LOW_MASK) == 64'd0);

  assert_ver_write_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && req_addr == 4'd10) |-> acc_err);
endmodule

bind strand_timer_regs stv_checker #(.TBA_ZERO_BITS(TBA_ZERO_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_we     (req_we),
  .req_addr   (req_addr),
  .rd_data    (rd_data),
  .acc_err    (acc_err),
  .soft_tick  (softint_o[0]),
  .soft_stick (softint_o[16]),
  .hint_o     (hint_o),
  .tick_cnt   (tick_cnt),
  .cmp_fire   (cmp_fire),
  .cmp_dis    (cmp_dis)
);

// File: tb/strand_timer_regs_tb.sv
`timescale 1ns/1ps
module strand_timer_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [3:0]  req_addr = 4'd0;
  logic [63:0] req_wdata = 64'd0;
  logic [63:0] rd_data;
  logic        acc_err;
  logic [16:0] softint_o;
  logic        hint_o;

  int checks = 0;
  int errors = 0;
  logic last_err;

  always #2.5 clk = ~clk;

  strand_timer_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .acc_err(acc_err), .softint_o(softint_o), .hint_o(hint_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; returns at the next falling edge (after the write lands)
  task automatic do_write(input logic [3:0] a, input logic [63:0] d);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    #1 last_err = acc_err;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [63:0] d, output logic e);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    #1 d = rd_data; e = acc_err;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] v; logic e;
    chk("R7 reset softint", 64'(softint_o), 64'd0);
    chk("R7 reset hint", 64'(hint_o), 64'd0);
    do_read(4'd0, v, e);
    chk("R1 tick first cycle", v, 64'd0);
    do_read(4'd0, v, e);
    chk("R1 tick step", v, 64'd1);
    do_read(4'd1, v, e);
    chk("R1 stick step", v, 64'd2);
    do_read(4'd2, v, e);
    chk("R13 cmp reset", v, 64'd0);
  endtask

  // Program compare at addr so it matches d cycles after the write cycle, watch pending bit
  task automatic arm_and_watch(input string req, input logic [3:0] cmp_a, input logic [3:0] cnt_a,
                               input int d, input int bit_sel);
    logic [63:0] c; logic e;
    do_read(cnt_a, c, e);
    do_write(cmp_a, c + 64'd1 + 64'(d));
    repeat (d - 1) @(negedge clk);
    chk({req, " before match"}, 64'(bit_sel < 0 ? hint_o : softint_o[bit_sel]), 64'd0);
    @(negedge clk);
    chk({req, " at match"}, 64'(bit_sel < 0 ? hint_o : softint_o[bit_sel]), 64'd1);
  endtask

  task automatic t_fire();
    logic [63:0] v; logic e;
    arm_and_watch("R2 tick d=5", 4'd2, 4'd0, 5, 0);
    chk("R3 tick leaves bit16", 64'(softint_o[16]), 64'd0);
    do_write(4'd5, 64'd0);
    arm_and_watch("R2 tick d=1", 4'd2, 4'd0, 1, 0);
    do_write(4'd5, 64'd0);
    arm_and_watch("R3 stick", 4'd3, 4'd1, 4, 16);
    chk("R3 stick leaves bit0", 64'(softint_o[0]), 64'd0);
    arm_and_watch("R3 hstick", 4'd4, 4'd1, 6, -1);
    chk("R3 hstick leaves softint", 64'(softint_o), 64'h10000);
    do_write(4'd8, 64'd0);
    chk("R7 hint cleared", 64'(hint_o), 64'd0);
    do_write(4'd5, 64'd0);
    do_read(4'd3, v, e);
    chk("R13 stick cmp readback", v[63], 1'b0);
  endtask

  task automatic t_disabled();
    logic [63:0] c, v; logic e;
    do_read(4'd0, c, e);
    do_write(4'd2, (64'd1 << 63) | (c + 64'd4));
    repeat (12) @(negedge clk);
    chk("R4 disabled tick", 64'(softint_o[0]), 64'd0);
    do_read(4'd2, v, e);
    chk("R13 cmp bit63 readback", v, (64'd1 << 63) | (c + 64'd4));
  endtask

  task automatic t_past();
    logic [63:0] c; logic e;
    do_read(4'd0, c, e);
    do_write(4'd2, c + 64'd1);
    repeat (10) @(negedge clk);
    chk("R5 equal to counter", 64'(softint_o[0]), 64'd0);
    do_read(4'd1, c, e);
    do_write(4'd3, c - 64'd3);
    repeat (10) @(negedge clk);
    chk("R5 behind counter", 64'(softint_o[16]), 64'd0);
  endtask

  task automatic t_cancel();
    logic [63:0] c; logic e;
    do_read(4'd0, c, e);
    do_write(4'd2, c + 64'd9);
    do_write(4'd2, c + 64'd5000);
    repeat (20) @(negedge clk);
    chk("R6 rewrite cancels", 64'(softint_o[0]), 64'd0);
    do_write(4'd2, 64'd1 << 63);
  endtask

  task automatic t_alias();
    logic [63:0] v; logic e;
    do_write(4'd5, 64'h000F0);
    chk("R7 direct write", 64'(softint_o), 64'h000F0);
    do_write(4'd6, 64'h11003);
    chk("R8 set alias", 64'(softint_o), 64'h110F3);
    do_write(4'd7, 64'h10030);
    do_read(4'd5, v, e);
    chk("R9 clear alias", v, 64'h010C3);
    repeat (5) @(negedge clk);
    chk("R7 bits hold", 64'(softint_o), 64'h010C3);
    do_write(4'd7, 64'h1FFFF);
    chk("R9 clear all", 64'(softint_o), 64'd0);
  endtask

  task automatic t_tba();
    logic [63:0] v; logic e;
    do_write(4'd9, '1);
    do_read(4'd9, v, e);
    chk("R10 tba all ones", v, 64'hFFFF_FFFF_FFFF_8000);
    do_write(4'd9, 64'h1234_5678_9ABC_DEF0);
    do_read(4'd9, v, e);
    chk("R10 tba pattern", v, 64'h1234_5678_9ABC_8000);
  endtask

  task automatic t_version_err();
    logic [63:0] v, c; logic e;
    do_read(4'd10, v, e);
    chk("R11 version word", v, 64'h0003_0608);
    chk("R12 version read legal", 64'(e), 64'd0);
    do_write(4'd10, 64'hFFFF);
    chk("R12 version write err", 64'(last_err), 64'd1);
    do_read(4'd10, v, e);
    chk("R12 version unchanged", v, 64'h0003_0608);
    do_read(4'd12, v, e);
    chk("R12 unmapped read err", 64'(e), 64'd1);
    do_write(4'd13, 64'd5);
    chk("R12 unmapped write err", 64'(last_err), 64'd1);
    do_read(4'd0, c, e);
    do_write(4'd0, 64'd0);
    chk("R12 tick write err", 64'(last_err), 64'd1);
    do_read(4'd0, v, e);
    chk("R12 tick unaffected", v, c + 64'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fire();
    t_disabled();
    t_past();
    t_cancel();
    t_alias();
    t_tba();
    t_version_err();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule